// File: doc/BRIEF.md
# Phase Comparator with Digital Charge-Pump Accumulator

This block decides whether a feedback clock is behind or ahead of a reference clock and turns that decision into a signed control word. Both clocks enter as ordinary signals and are sampled by a faster system clock. Each input goes through a short synchroniser. Only its rising edge is used. A reference edge raises `up_o` and a feedback edge raises `dn_o`. When both flags are high they drop together one cycle later. The difference between the two pulse widths therefore measures the phase error in sample cycles. The inverted pair is produced inside the block and comes from its own flops.

A saturating accumulator stands in for the charge pump and loop capacitor. It adds a fixed step while only `up_o` is high. It subtracts the same step while only `dn_o` is high. It holds its value when both flags are low or both are high, because equal charge and discharge steps cancel. A digital oscillator downstream can read the control word directly. Every pin is a plain level signal, so there is no handshake and no back-pressure.

Top module: `phase_cmp_pump`

## Requirements
- R1: While reset is asserted and right after it is released, `up_o` and `dn_o` are 0, `up_no` and `dn_no` are 1, and `ctrl_o` is 0.
- R2: A rising edge on `ref_i` sets `up_o` on the third rising sample edge after `ref_i` goes high, and not before.
- R3: When the feedback rising edge comes d sample cycles after the reference rising edge, `up_o` is high for d+1 cycles and `dn_o` is high for exactly 1 cycle.
- R4: When the feedback rising edge comes d cycles before the reference rising edge, `dn_o` is high for d+1 cycles and `up_o` is high for exactly 1 cycle.
- R5: Reference and feedback edges that are aligned give exactly one cycle in which both flags are high. Both flags are low on the next cycle.
- R6: `up_no` is always the inverse of `up_o`, and `dn_no` is always the inverse of `dn_o`.
- R7: In each cycle with `up_o`=1 and `dn_o`=0, `ctrl_o` rises by STEP (default 4) on the next edge, unless that would pass the maximum.
- R8: In each cycle with `dn_o`=1 and `up_o`=0, `ctrl_o` falls by STEP on the next edge, unless that would pass the minimum.
- R9: In a cycle with both flags low, `ctrl_o` does not change.
- R10: In a cycle with both flags high, `ctrl_o` does not change. As a result, a lag of d cycles changes `ctrl_o` by +d·STEP in total, and a lead of d cycles changes it by −d·STEP.
- R11: Falling edges on `ref_i` and `fb_i` have no effect on either flag or on `ctrl_o`.
- R12: `ctrl_o` is a two's-complement number CTRL_W bits wide (default 12). It stops at +2047 and at −2048 and never wraps around.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ref_i | input | 1 | Reference clock, treated as a sampled signal |
| fb_i | input | 1 | Feedback clock, treated as a sampled signal |
| up_o | output | 1 | Speed-up flag |
| dn_o | output | 1 | Slow-down flag |
| up_no | output | 1 | Inverse of up_o |
| dn_no | output | 1 | Inverse of dn_o |
| ctrl_o | output | CTRL_W | Signed, saturating control word |

## Verification
The comparator is driven with pairs of edges in which the feedback edge lags by 1 and by 3 cycles, leads by 5 cycles, or arrives aligned with the reference edge. These cases test the sign of the response, the extra pulse cycle and the single-cycle overlap. One more case lowers one input while the other stays high, to confirm that falling edges change nothing. Long stretches of a single edge with no partner drive the word into each saturation limit. This shows that the word stops at the limit instead of wrapping. A quiet stretch confirms that the word holds.

// File: rtl/pcp_pkg.sv
package pcp_pkg;
  localparam int CTRL_W_DEF = 12;
  localparam int STEP_DEF   = 4;
  localparam int SYNC_DEF   = 2;
  localparam int N_IN       = 2;
  localparam int IDX_REF    = 0;
  localparam int IDX_FB     = 1;
endpackage

// File: rtl/pcp_edge_sync.sv
module pcp_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sig_i,
  output logic rise_o
);
  // chain[STAGES-1] is the synchronised level; chain[STAGES] is one cycle older.
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-1:0], sig_i};
  end

  assign rise_o = chain_q[STAGES-1] & ~chain_q[STAGES];

  // R11: only a rising edge makes a pulse, and it lasts one cycle.
  a_r11_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/pcp_flag_core.sv
module pcp_flag_core (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ref_rise_i,
  input  logic fb_rise_i,
  output logic up_o,
  output logic dn_o,
  output logic up_no,
  output logic dn_no
);
  logic up_q, dn_q, up_n_q, dn_n_q;
  logic up_d, dn_d;

  always_comb begin
    if (up_q && dn_q) begin
      up_d = 1'b0;
      dn_d = 1'b0;
    end else begin
      up_d = up_q | ref_rise_i;
      dn_d = dn_q | fb_rise_i;
    end
  end

  // The inverted pair comes from separate flops, so it carries no inverter delay.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      up_q   <= 1'b0;
      dn_q   <= 1'b0;
      up_n_q <= 1'b1;
      dn_n_q <= 1'b1;
    end else begin
      up_q   <= up_d;
      dn_q   <= dn_d;
      up_n_q <= ~up_d;
      dn_n_q <= ~dn_d;
    end
  end

  assign up_o  = up_q;
  assign dn_o  = dn_q;
  assign up_no = up_n_q;
  assign dn_no = dn_n_q;

  // R5: an overlap of both flags lasts a single cycle.
  a_r5_overlap_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q && dn_q) |=> (!up_q && !dn_q));
  // R6: each inverted output stays opposite to its true output.
  a_r6_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_q ^ up_n_q) && (dn_q ^ dn_n_q));
  // R2: up rises only when a reference edge is present.
  a_r2_up_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_q && !ref_rise_i) |=> !up_q);
endmodule

// File: rtl/pcp_pump_accum.sv
module pcp_pump_accum #(
  parameter int W    = 12,
  parameter int STEP = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                up_i,
  input  logic                dn_i,
  output logic signed [W-1:0] acc_o
);
  localparam logic signed [W-1:0] MAX_V    = {1'b0, {(W-1){1'b1}}};
  localparam logic signed [W-1:0] MIN_V    = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] STEP_W   = W'(STEP);
  localparam logic signed [W-1:0] HI_GUARD = MAX_V - STEP_W;
  localparam logic signed [W-1:0] LO_GUARD = MIN_V + STEP_W;
  localparam logic signed [W:0]   HI_EXT   = {1'b0, MAX_V};
  localparam logic signed [W:0]   LO_EXT   = {1'b1, MIN_V};
  localparam logic signed [W:0]   STEP_EXT = (W+1)'(STEP);

  logic signed [W-1:0] acc_q, acc_d;
  logic signed [W:0]   ext, sum;

  always_comb begin
    ext = {acc_q[W-1], acc_q};
    unique case ({up_i, dn_i})
      2'b10:   sum = ext + STEP_EXT;
      2'b01:   sum = ext - STEP_EXT;
      default: sum = ext;
    endcase
    if (sum > HI_EXT)      acc_d = MAX_V;
    else if (sum < LO_EXT) acc_d = MIN_V;
    else                   acc_d = sum[W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_d;
  end

  assign acc_o = acc_q;

  a_r7_charge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && !dn_i && acc_q <= HI_GUARD) |=> acc_q == $past(acc_q) + STEP_W);
  a_r8_discharge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_i && !up_i && acc_q >= LO_GUARD) |=> acc_q == $past(acc_q) - STEP_W);
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!up_i && !dn_i) |=> $stable(acc_q));
  a_r10_overlap_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && dn_i) |=> $stable(acc_q));
  a_r12_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == MAX_V && up_i) |=> acc_q == MAX_V);
  a_r12_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_q == MIN_V && dn_i) |=> acc_q == MIN_V);
endmodule

// File: rtl/phase_cmp_pump.sv
module phase_cmp_pump
  import pcp_pkg::*;
#(
  parameter int CTRL_W = CTRL_W_DEF,
  parameter int STEP   = STEP_DEF,
  parameter int SYNC_N = SYNC_DEF
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ref_i,
  input  logic                     fb_i,
  output logic                     up_o,
  output logic                     dn_o,
  output logic                     up_no,
  output logic                     dn_no,
  output logic signed [CTRL_W-1:0] ctrl_o
);
  logic [N_IN-1:0] raw, rise;
  logic            up_w, dn_w;

  assign raw[IDX_REF] = ref_i;
  assign raw[IDX_FB]  = fb_i;

  for (genvar g = 0; g < N_IN; g++) begin : g_sync
    pcp_edge_sync #(.STAGES(SYNC_N)) u_sync (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .sig_i (raw[g]),
      .rise_o(rise[g])
    );
  end

  pcp_flag_core u_flags (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ref_rise_i(rise[IDX_REF]),
    .fb_rise_i (rise[IDX_FB]),
    .up_o      (up_w),
    .dn_o      (dn_w),
    .up_no     (up_no),
    .dn_no     (dn_no)
  );

  pcp_pump_accum #(.W(CTRL_W), .STEP(STEP)) u_pump (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .up_i  (up_w),
    .dn_i  (dn_w),
    .acc_o (ctrl_o)
  );

  assign up_o = up_w;
  assign dn_o = dn_w;
endmodule

// File: tb/test_phase_cmp_pump.sv
module test_phase_cmp_pump;
  localparam int STEP = 4;
  localparam int MAXV = 2047;
  localparam int MINV = -2048;

  logic clk = 1'b0, rst_n = 1'b0, ref_s = 1'b0, fb_s = 1'b0;
  logic up, dn, up_n, dn_n;
  logic signed [11:0] ctrl;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  phase_cmp_pump i_phase_cmp_pump (
    .clk_i(clk), .rst_ni(rst_n), .ref_i(ref_s), .fb_i(fb_s),
    .up_o(up), .dn_o(dn), .up_no(up_n), .dn_no(dn_n), .ctrl_o(ctrl)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_s = 1'b0; fb_s = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    do_reset();
    chk(up == 1'b0, "R1 up", int'(up), 0);
    chk(dn == 1'b0, "R1 dn", int'(dn), 0);
    chk(up_n == 1'b1, "R1 up_n", int'(up_n), 1);
    chk(dn_n == 1'b1, "R1 dn_n", int'(dn_n), 1);
    chk(ctrl == 0, "R1 ctrl", int'(ctrl), 0);
  endtask

  task automatic t_latency();
    @(negedge clk); ref_s = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(up == 1'b0, "R2 up early", int'(up), 0);
    @(negedge clk);
    chk(up == 1'b1, "R2 up on third edge", int'(up), 1);
    fb_s = 1'b1;
    repeat (6) @(negedge clk);
    ref_s = 1'b0; fb_s = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // lag > 0: the feedback edge comes after the reference edge.
  task automatic t_pair(input int lag);
    int tr, tf, tend, w_up, w_dn, w_both, acc0, step_bad, cmp_bad, exp_up, exp_dn;
    logic p_up, p_dn;
    int p_ctrl;
    tr = (lag >= 0) ? 2 : 2 - lag;
    tf = tr + lag;
    tend = ((tr > tf) ? tr : tf) + 5;
    w_up = 0; w_dn = 0; w_both = 0; step_bad = 0; cmp_bad = 0;
    acc0 = int'(ctrl);
    p_up = up; p_dn = dn; p_ctrl = int'(ctrl);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == tr) ref_s = 1'b1;
      if (i == tf) fb_s = 1'b1;
      if (i == tend) begin ref_s = 1'b0; fb_s = 1'b0; end
      if (up) w_up++;
      if (dn) w_dn++;
      if (up && dn) w_both++;
      if ((up_n !== ~up) || (dn_n !== ~dn)) cmp_bad++;
      if (p_up && !p_dn && int'(ctrl) != p_ctrl + STEP) step_bad++;
      if (p_dn && !p_up && int'(ctrl) != p_ctrl - STEP) step_bad++;
      if (p_up == p_dn && int'(ctrl) != p_ctrl) step_bad++;
      p_up = up; p_dn = dn; p_ctrl = int'(ctrl);
    end
    exp_up = (lag >= 0) ? lag + 1 : 1;
    exp_dn = (lag <= 0) ? 1 - lag : 1;
    if (lag > 0) begin
      chk(w_up == exp_up, "R3 up width", w_up, exp_up);
      chk(w_dn == exp_dn, "R3 dn width", w_dn, exp_dn);
    end else if (lag < 0) begin
      chk(w_dn == exp_dn, "R4 dn width", w_dn, exp_dn);
      chk(w_up == exp_up, "R4 up width", w_up, exp_up);
    end else begin
      chk(w_up == 1 && w_dn == 1, "R5 widths", w_up + w_dn, 2);
    end
    chk(w_both == 1, "R5 overlap cycles", w_both, 1);
    chk(cmp_bad == 0, "R6 complement mismatches", cmp_bad, 0);
    chk(step_bad == 0, "R7 R8 R9 R10 per-cycle steps", step_bad, 0);
    chk(int'(ctrl) - acc0 == lag * STEP, "R10 net change", int'(ctrl) - acc0, lag * STEP);
  endtask

  task automatic t_hold();
    int v0, bad;
    v0 = int'(ctrl); bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (int'(ctrl) != v0 || up || dn) bad++;
    end
    chk(bad == 0, "R9 idle hold", bad, 0);
  endtask

  task automatic t_fall();
    int v0;
    @(negedge clk); ref_s = 1'b1; fb_s = 1'b1;
    repeat (8) @(negedge clk);
    v0 = int'(ctrl);
    ref_s = 1'b0;
    repeat (8) @(negedge clk);
    chk(!up && !dn && int'(ctrl) == v0, "R11 ref fall ignored", int'(ctrl), v0);
    fb_s = 1'b0;
    repeat (8) @(negedge clk);
    chk(!up && !dn && int'(ctrl) == v0, "R11 fb fall ignored", int'(ctrl), v0);
  endtask

  task automatic t_sat();
    do_reset();
    ref_s = 1'b1;
    repeat (5) @(negedge clk);
    ref_s = 1'b0;
    repeat (600) @(negedge clk);
    chk(int'(ctrl) == MAXV, "R12 clamp at max", int'(ctrl), MAXV);
    chk(up == 1'b1, "R12 up still held", int'(up), 1);
    fb_s = 1'b1;
    repeat (8) @(negedge clk);
    fb_s = 1'b0;
    chk(int'(ctrl) == MAXV && !up && !dn, "R12 max kept after clear", int'(ctrl), MAXV);
    do_reset();
    fb_s = 1'b1;
    repeat (5) @(negedge clk);
    fb_s = 1'b0;
    repeat (600) @(negedge clk);
    chk(int'(ctrl) == MINV, "R12 clamp at min", int'(ctrl), MINV);
    ref_s = 1'b1;
    repeat (8) @(negedge clk);
    ref_s = 1'b0;
    chk(int'(ctrl) == MINV && !up && !dn, "R12 min kept after clear", int'(ctrl), MINV);
  endtask

  initial begin
    t_reset();
    t_latency();
    t_pair(3);
    t_pair(-5);
    t_pair(0);
    t_pair(1);
    t_hold();
    t_fall();
    t_sat();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule